// File: doc/BRIEF.md
# Ring-Walking Packet Receive Channel

This block moves received packets from a byte stream into memory buffers. Software builds a ring of 8-byte descriptors in memory and programs the address of the first one. Each descriptor holds a buffer size and a status half-word in its first word, and a buffer address in its second word. The channel reads the current descriptor and checks whether software has handed it over. It then packs incoming bytes into 32-bit words, writes them to the buffer, and writes back the received length and a completion status that returns the descriptor to software. Finally it moves on to the next descriptor, or back to the ring start when the descriptor carries the wrap flag.

Software controls the channel through a small register port. It can start the channel, ask it to stop cleanly after the packet in progress, or ask it to stop as soon as the current memory transaction ends. A channel-reset write returns the ring position to the programmed start. If the current descriptor is not yet handed over, the channel holds the stream off and reads the descriptor again at a fixed interval, or at once when software writes the start bit again.

Top module: `rxdma_chan`

## Requirements
- R1: After reset the channel is stopped: `mem_req` and `s_ready` are 0 and the control register (select 0) reads 0.
- R2: A descriptor is read as two aligned 32-bit words at the ring position: the word at offset 0 holds the buffer size in bits 31:16 and status in bits 15:0, and the word at offset 4 holds the buffer address. A request holds its address until `mem_ack`.
- R3: A descriptor whose status bit 15 (hand-over) is 0 is never used. The stream is held off (`s_ready` = 0), and the descriptor is read again after `POLL_CYCLES` cycles, or right after a control write with bit 0 set.
- R4: Payload bytes are packed big-endian (first byte in bits 31:24) and written at buffer address + 4k. A final partial word is padded with zero bytes.
- R5: On completion the word at offset 0 is rewritten with the stored length in bits 31:16 and a status with bit 15 = 0, bit 14 = 1 (end of packet), bit 13 = 1 (start of packet), bit 12 copied from the fetched wrap flag, and all other bits 0 except bit 4.
- R6: After a descriptor with status bit 12 set, the next descriptor is read at the ring start; otherwise it is read 8 bytes further on.
- R7: Bytes beyond the descriptor's buffer size are still accepted but not written. The stored length equals the buffer size, and status bit 4 (oversize) is set.
- R8: Control bit 1 stops the channel at the next packet boundary. A packet already in progress is completed first. Control bit 0 reads 1 until the channel has stopped, then 0. Setting bit 0 again resumes at the next descriptor.
- R9: Control bit 2 stops the channel after the current memory transaction, even in the middle of a packet. The descriptor is not handed back, and control bit 0 reads 0 once stopped.
- R10: Writing 1 to bit 0 of select 2 stops the channel and sets the ring position to the programmed start (select 1), so the next fetch reads the first descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 ring start, 2 channel reset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transaction complete |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of a packet |
| s_ready | output | 1 | Channel accepts the byte |

## Verification
A table of packets walks the ring through all three descriptors and back past the wrap. It uses lengths of one byte, an exact word, a partial word, two full words, and a packet larger than its buffer. These cases separate zero-padding, word-boundary handling, truncation and wrap-to-start from the ordinary 8-byte step. Directed sequences then distinguish the two halt modes by issuing each in the middle of a packet: the packet-boundary halt must still hand the descriptor back, while the transaction-boundary halt must leave it owned. A channel reset after a halt is told apart from a plain restart by checking that the first descriptor, not the next one, receives the packet.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_POLL,
    ST_RECV,
    ST_WRD,
    ST_WRS
  } eng_state_e;

  // status half-word bit positions (hardware-visible layout)
  localparam int OWN_BIT  = 15;
  localparam int EOP_BIT  = 14;
  localparam int SOP_BIT  = 13;
  localparam int WRAP_BIT = 12;
  localparam int OVSZ_BIT = 4;

  localparam int LEN_W      = 16;
  localparam int WORD_W     = 32;
  localparam int WORD_LANES = WORD_W / 8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_RST  = 2'd2;

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs
  import rxdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          eng_stop,
  output logic          enable,
  output logic          halt_pkt,
  output logic          halt_burst,
  output logic [AW-1:0] ring_base,
  output logic          kick,
  output logic          chan_rst,
  output logic          reload
);

  logic          ctrl_wr, base_wr;
  logic          enable_nx, halt_pkt_nx, halt_burst_nx, reload_nx;
  logic [AW-1:0] ring_base_nx;

  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign base_wr  = reg_wr && (reg_sel == SEL_BASE);
  assign chan_rst = reg_wr && (reg_sel == SEL_RST) && reg_wdata[0];
  assign kick     = ctrl_wr && reg_wdata[0];

  always_comb begin
    enable_nx     = enable;
    halt_pkt_nx   = halt_pkt;
    halt_burst_nx = halt_burst;
    ring_base_nx  = ring_base;
    reload_nx     = base_wr || chan_rst;
    if (base_wr) ring_base_nx = reg_wdata[AW-1:0];
    if (chan_rst) begin
      enable_nx     = 1'b0;
      halt_pkt_nx   = 1'b0;
      halt_burst_nx = 1'b0;
    end else if (kick) begin
      enable_nx     = 1'b1;
      halt_pkt_nx   = 1'b0;
      halt_burst_nx = 1'b0;
    end else if (eng_stop) begin
      enable_nx     = 1'b0;
      halt_pkt_nx   = 1'b0;
      halt_burst_nx = 1'b0;
    end else if (ctrl_wr) begin
      halt_pkt_nx   = halt_pkt   | reg_wdata[1];
      halt_burst_nx = halt_burst | reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      halt_pkt   <= 1'b0;
      halt_burst <= 1'b0;
      ring_base  <= '0;
      reload     <= 1'b0;
    end else begin
      enable     <= enable_nx;
      halt_pkt   <= halt_pkt_nx;
      halt_burst <= halt_burst_nx;
      ring_base  <= ring_base_nx;
      reload     <= reload_nx;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {29'd0, halt_burst, halt_pkt, enable};
      SEL_BASE: reg_rdata = 32'(ring_base);
      default:  reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [LANES*8-1:0] word,
  output logic [$clog2(LANES+1)-1:0] fill
);

  localparam int FW = $clog2(LANES + 1);

  logic [FW-1:0] fill_nx;

  always_comb begin
    fill_nx = fill;
    if (clr)       fill_nx = '0;
    else if (push) fill_nx = fill + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill <= '0;
    else        fill <= fill_nx;
  end

  // one byte lane per generate step; lane 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q, lane_nx;
    always_comb begin
      lane_nx = lane_q;
      if (clr)                               lane_nx = '0;
      else if (push && (fill == FW'(g)))     lane_nx = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_nx;
    end
    assign word[(LANES-1-g)*8 +: 8] = lane_q;
  end

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int POLL_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                halt_pkt,
  input  logic                halt_burst,
  input  logic                kick,
  input  logic                chan_rst,
  input  logic                reload,
  input  logic [AW-1:0]       ring_base,
  output logic                eng_stop,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ack,
  input  logic                s_valid,
  input  logic [7:0]          s_data,
  input  logic                s_last,
  output logic                s_ready,
  output logic                pk_clr,
  output logic                pk_push,
  input  logic [WORD_W-1:0]   pk_word,
  input  logic [$clog2(WORD_LANES+1)-1:0] pk_fill
);

  localparam int FW = $clog2(WORD_LANES + 1);
  localparam int PW = $clog2(POLL_CYCLES + 1);
  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [AW-1:0] WORD_STEP = AW'(WORD_LANES);

  eng_state_e        state_q, state_nx;
  logic [AW-1:0]     cur_q, cur_nx, bufp_q, bufp_nx;
  logic [LEN_W-1:0]  blen_q, blen_nx, stored_q, stored_nx;
  logic              own_q, own_nx, wrap_q, wrap_nx;
  logic              any_q, any_nx, trunc_q, trunc_nx, done_q, done_nx;
  logic [PW-1:0]     poll_q, poll_nx;

  logic              accept, store, full_now, recv_halt;
  logic [LEN_W-1:0]  status_out;

  assign recv_halt = halt_burst || (halt_pkt && !any_q);
  assign s_ready   = (state_q == ST_RECV) && !recv_halt;
  assign accept    = s_valid && s_ready;
  assign store     = accept && (stored_q < blen_q);
  assign full_now  = store && (pk_fill == FW'(WORD_LANES - 1));

  always_comb begin
    status_out           = '0;
    status_out[EOP_BIT]  = 1'b1;
    status_out[SOP_BIT]  = 1'b1;
    status_out[WRAP_BIT] = wrap_q;
    status_out[OVSZ_BIT] = trunc_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (state_q)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin mem_req = 1'b1; mem_addr = cur_q + AW'(4); end
      ST_WRD: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = bufp_q; mem_wdata = pk_word; end
      ST_WRS: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = {stored_q, status_out}; end
      default: ;
    endcase
  end

  always_comb begin
    state_nx  = state_q;
    cur_nx    = cur_q;
    bufp_nx   = bufp_q;
    blen_nx   = blen_q;
    stored_nx = stored_q;
    own_nx    = own_q;
    wrap_nx   = wrap_q;
    any_nx    = any_q;
    trunc_nx  = trunc_q;
    done_nx   = done_q;
    poll_nx   = poll_q;
    eng_stop  = 1'b0;
    pk_clr    = 1'b0;
    pk_push   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (enable) begin
          if (halt_pkt || halt_burst) eng_stop = 1'b1;
          else                        state_nx = ST_RD0;
        end
      end
      ST_RD0: begin
        if (mem_ack) begin
          blen_nx = mem_rdata[31:16];
          own_nx  = mem_rdata[OWN_BIT];
          wrap_nx = mem_rdata[WRAP_BIT];
          if (halt_burst) begin eng_stop = 1'b1; state_nx = ST_IDLE; end
          else            state_nx = ST_RD1;
        end
      end
      ST_RD1: begin
        if (mem_ack) begin
          bufp_nx = mem_rdata[AW-1:0];
          if (halt_burst) begin
            eng_stop = 1'b1;
            state_nx = ST_IDLE;
          end else if (own_q) begin
            state_nx  = ST_RECV;
            stored_nx = '0;
            any_nx    = 1'b0;
            trunc_nx  = 1'b0;
            done_nx   = 1'b0;
            pk_clr    = 1'b1;
          end else begin
            state_nx = ST_POLL;
            poll_nx  = '0;
          end
        end
      end
      ST_POLL: begin
        if (halt_pkt || halt_burst) begin
          eng_stop = 1'b1;
          state_nx = ST_IDLE;
        end else if (kick || (poll_q == PW'(POLL_CYCLES - 1))) begin
          state_nx = ST_RD0;
        end else begin
          poll_nx = poll_q + PW'(1);
        end
      end
      ST_RECV: begin
        if (recv_halt) begin
          eng_stop = 1'b1;
          pk_clr   = 1'b1;
          state_nx = ST_IDLE;
        end else if (accept) begin
          any_nx = 1'b1;
          if (store) begin
            pk_push   = 1'b1;
            stored_nx = stored_q + LEN_W'(1);
          end else begin
            trunc_nx = 1'b1;
          end
          if (s_last) begin
            done_nx  = 1'b1;
            state_nx = (store || (pk_fill != '0)) ? ST_WRD : ST_WRS;
          end else if (full_now) begin
            state_nx = ST_WRD;
          end
        end
      end
      ST_WRD: begin
        if (mem_ack) begin
          pk_clr  = 1'b1;
          bufp_nx = bufp_q + WORD_STEP;
          if (halt_burst) begin eng_stop = 1'b1; state_nx = ST_IDLE; end
          else            state_nx = done_q ? ST_WRS : ST_RECV;
        end
      end
      ST_WRS: begin
        if (mem_ack) begin
          cur_nx = wrap_q ? ring_base : cur_q + DESC_STEP;
          if (halt_pkt || halt_burst) begin eng_stop = 1'b1; state_nx = ST_IDLE; end
          else                        state_nx = ST_RD0;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
    if (reload) cur_nx = ring_base;
    if (chan_rst) begin
      state_nx = ST_IDLE;
      pk_clr   = 1'b1;
      pk_push  = 1'b0;
      eng_stop = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      bufp_q   <= '0;
      blen_q   <= '0;
      stored_q <= '0;
      own_q    <= 1'b0;
      wrap_q   <= 1'b0;
      any_q    <= 1'b0;
      trunc_q  <= 1'b0;
      done_q   <= 1'b0;
      poll_q   <= '0;
    end else begin
      state_q  <= state_nx;
      cur_q    <= cur_nx;
      bufp_q   <= bufp_nx;
      blen_q   <= blen_nx;
      stored_q <= stored_nx;
      own_q    <= own_nx;
      wrap_q   <= wrap_nx;
      any_q    <= any_nx;
      trunc_q  <= trunc_nx;
      done_q   <= done_nx;
      poll_q   <= poll_nx;
    end
  end

  // R2: every access is word aligned
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R2: a pending request keeps its address until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !chan_rst) |=> (mem_req && $stable(mem_addr)));

  // R3: payload is only taken into a handed-over descriptor
  a_r3_owned_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV) |-> own_q);

  // R5: completion write returns the descriptor with both packet marks
  a_r5_handback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state_q == ST_WRS) |->
      (!mem_wdata[OWN_BIT] && mem_wdata[EOP_BIT] && mem_wdata[SOP_BIT]));

  // R7: reported length never exceeds the buffer size
  a_r7_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state_q == ST_WRS) |-> (mem_wdata[31:16] <= blen_q));

  // R9: stream and memory port are never busy together
  a_r9_stream_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !mem_req);

endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
  import rxdma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int POLL_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready
);

  localparam int FW = $clog2(WORD_LANES + 1);

  logic [1:0]      rs_q;
  logic            rst_i_n;
  logic            enable, halt_pkt, halt_burst, kick, chan_rst, reload, eng_stop;
  logic [AW-1:0]   ring_base;
  logic            pk_clr, pk_push;
  logic [WORD_W-1:0] pk_word;
  logic [FW-1:0]   pk_fill;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  rxdma_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_stop   (eng_stop),
    .enable     (enable),
    .halt_pkt   (halt_pkt),
    .halt_burst (halt_burst),
    .ring_base  (ring_base),
    .kick       (kick),
    .chan_rst   (chan_rst),
    .reload     (reload)
  );

  rxdma_packer #(.LANES(WORD_LANES)) u_pack (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (pk_clr),
    .push  (pk_push),
    .din   (s_data),
    .word  (pk_word),
    .fill  (pk_fill)
  );

  rxdma_engine #(.AW(AW), .POLL_CYCLES(POLL_CYCLES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .enable     (enable),
    .halt_pkt   (halt_pkt),
    .halt_burst (halt_burst),
    .kick       (kick),
    .chan_rst   (chan_rst),
    .reload     (reload),
    .ring_base  (ring_base),
    .eng_stop   (eng_stop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .pk_clr     (pk_clr),
    .pk_push    (pk_push),
    .pk_word    (pk_word),
    .pk_fill    (pk_fill)
  );

endmodule

// File: tb/tb_rxdma_chan.sv
`timescale 1ns/1ps
module tb_rxdma_chan;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        s_valid, s_last, s_ready;
  logic [7:0]  s_data;

  logic [31:0] mem [64];
  logic        tb_we;
  logic [5:0]  tb_idx;
  logic [31:0] tb_val;

  int n_tests = 0;
  int n_fail  = 0;

  rxdma_chan #(.AW(32), .POLL_CYCLES(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // zero-wait memory model, single writer process
  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
    end else begin
      if (tb_we) mem[tb_idx] <= tb_val;
      if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end
  end

  localparam int NV = 5;
  localparam int T_LEN [NV] = '{5, 8, 1, 20, 4};
  localparam int T_BUF [NV] = '{16, 16, 16, 12, 16};
  localparam logic [7:0] T_SEED [NV] = '{8'h10, 8'h30, 8'hA0, 8'h51, 8'hC4};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mem_put(input int idx, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_idx = 6'(idx); tb_val = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] seed, input int first, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = seed + 8'(first + i);
      s_last  = with_last && (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_handback(input int idx);
    int t = 0;
    while (mem[idx][15] && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int stored, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      if (4 * w + b < stored) r[31 - 8 * b -: 8] = seed + 8'(4 * w + b);
    end
    return r;
  endfunction

  task automatic clear_buf(input int d);
    for (int w = 0; w < 8; w++) mem_put(32 + 8 * d + w, 32'd0);
  endtask

  task automatic quiet_window(input int cycles, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (s_ready) seen = 1'b1;
    end
  endtask

  task automatic run_all();
    logic [31:0] v;
    bit seen;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 s_ready", {31'd0, s_ready}, 32'd0);
    reg_read(2'd0, v);
    chk("R1 ctrl", v, 32'd0);

    reg_write(2'd1, 32'h0000_0000);
    reg_write(2'd0, 32'd1);

    // table: R2 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      int d = k % 3;
      int stored = (T_LEN[k] < T_BUF[k]) ? T_LEN[k] : T_BUF[k];
      logic [15:0] st;
      clear_buf(d);
      mem_put(2 * d + 1, 32'h80 + 32'(32 * d));
      mem_put(2 * d, {16'(T_BUF[k]), 16'h8000 | ((d == 2) ? 16'h1000 : 16'h0)});
      send_bytes(T_LEN[k], T_SEED[k], 0, 1'b1);
      wait_handback(2 * d);
      st = 16'h6000 | ((d == 2) ? 16'h1000 : 16'h0) | ((T_LEN[k] > T_BUF[k]) ? 16'h0010 : 16'h0);
      chk((k == 3) ? "R7 status word" : "R5 status word", mem[2 * d], {16'(stored), st});
      for (int w = 0; w < 8; w++)
        chk((k == 3) ? "R7 buffer" : "R4 buffer", mem[32 + 8 * d + w], exp_word(T_SEED[k], stored, w));
      if (k == 3) chk("R6 no entry past wrap", mem[6], 32'd0);
    end

    // R3: descriptor 2 is not handed over now
    quiet_window(40, seen);
    chk("R3 stream held", {31'd0, seen}, 32'd0);
    chk("R2 unowned word untouched", mem[4], {16'd1, 16'h7000});
    clear_buf(2);
    mem_put(4, {16'd16, 16'h9000});
    reg_write(2'd0, 32'd1);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (s_ready) seen = 1'b1;
    end
    chk("R3 re-poll on kick", {31'd0, seen}, 32'd1);

    // R8: packet-boundary halt issued mid-packet
    send_bytes(3, 8'h60, 0, 1'b0);
    reg_write(2'd0, 32'd2);
    reg_read(2'd0, v);
    chk("R8 still running", v, 32'd3);
    send_bytes(3, 8'h60, 3, 1'b1);
    wait_handback(4);
    chk("R8 packet finished", mem[4], {16'd6, 16'h7000});
    chk("R8 data", mem[48], exp_word(8'h60, 6, 0));
    chk("R8 data tail", mem[49], exp_word(8'h60, 6, 1));
    repeat (4) @(negedge clk);
    reg_read(2'd0, v);
    chk("R8 stopped", v, 32'd0);
    clear_buf(0);
    mem_put(0, {16'd16, 16'h8000});
    quiet_window(30, seen);
    chk("R8 idle while halted", {31'd0, seen}, 32'd0);
    chk("R8 desc untouched", mem[0], {16'd16, 16'h8000});
    reg_write(2'd0, 32'd1);
    send_bytes(4, 8'h21, 0, 1'b1);
    wait_handback(0);
    chk("R8 resume at wrap target", mem[0], {16'd4, 16'h6000});

    // R9: transaction-boundary halt mid-packet on descriptor 1
    clear_buf(1);
    mem_put(2, {16'd16, 16'h8000});
    send_bytes(2, 8'h90, 0, 1'b0);
    reg_write(2'd0, 32'd4);
    repeat (5) @(negedge clk);
    reg_read(2'd0, v);
    chk("R9 stopped", v, 32'd0);
    chk("R9 stream held", {31'd0, s_ready}, 32'd0);
    chk("R9 desc kept", mem[2], {16'd16, 16'h8000});
    chk("R9 no partial write", mem[40], 32'd0);

    // R10: channel reset returns to the ring start
    reg_write(2'd2, 32'd1);
    clear_buf(0);
    mem_put(0, {16'd16, 16'h8000});
    reg_write(2'd0, 32'd1);
    send_bytes(5, 8'h77, 0, 1'b1);
    wait_handback(0);
    chk("R10 first desc used", mem[0], {16'd5, 16'h6000});
    chk("R10 data", mem[32], exp_word(8'h77, 5, 0));
    chk("R10 other desc kept", mem[2], {16'd16, 16'h8000});
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    tb_we = 1'b0; tb_idx = '0; tb_val = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule